// File: doc/BRIEF.md
# Smartcard Character Interface (reader side)

This block is the character layer between a host and an asynchronous smartcard, seen from the reader. The host pushes bytes into a transmit queue. The block frames each byte and serializes it onto the single, shared card I/O line. Bytes that the card sends on that line are sampled, checked and queued for the host to pop. The line is open-drain. The block never drives it high: it asserts an output enable only while the line must be pulled low, and an external pull-up sets the released level.

Bit timing comes from one elementary time unit (ETU), given as a number of clock cycles. The transmit and receive formats are set independently. Transmit uses eight data bits with even, odd or no parity and two stop bits. Receive accepts eight data bits with even, odd or no parity, or eight data bits plus a ninth data bit with no parity. One stop bit is enough for the receiver. A single switch selects the inverse coding convention for both directions. While the transmitter is busy, the receiver does not look at the line, so the block's own characters are not echoed into the receive queue.

Top module: `sc_char_if`

## Requirements
- R1: After reset, io_oe is low, tx_full is low, tx_drop is low and rx_empty is high.
- R2: A transmitted character on the line is: one low start bit, eight data bits, an optional parity bit, then two high stop bits. Each bit lasts cfg_etu clock cycles. In direct convention the data goes least significant bit first. cfg_tx_par selects the parity: 2'b01 even, 2'b10 odd, any other value none.
- R3: With cfg_inverse high, every data bit on the line is the complement of the logical bit, and the most significant bit goes first. Parity is computed over the line-level data bits. The receiver decodes the same way, and a ninth received bit is also complemented.
- R4: io_oe is high only while the line is to be held low. It is low whenever the transmitter is idle.
- R5: The transmit queue holds 16 bytes and sends them in push order. A push while tx_full is high is discarded, and tx_drop is high for one cycle on the clock after that push.
- R6: The receiver starts on a low level of the line. It confirms the start bit at mid-bit, then samples each following bit at mid-bit. It reads eight data bits plus a parity bit when cfg_rx_par is 2'b01 (even) or 2'b10 (odd).
- R7: A received character whose parity does not match is still queued, with rx_perr high in its entry. With no parity, rx_perr is low.
- R8: With cfg_rx_nine high, a ninth data bit is received after the eight data bits and stored in rx_data[8], and no parity is checked. Otherwise rx_data[8] is 0.
- R9: The receive queue holds 16 entries. A character completed while it is full is discarded. A pop while rx_empty is high has no effect.
- R10: While the transmitter is busy, the receiver ignores the line, so transmitted characters never enter the receive queue.
- R11: The receiver needs only one stop bit. Back-to-back characters with one stop bit and with two stop bits are both received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_etu | input | ETU_W | Clock cycles per elementary time unit (at least 4) |
| cfg_inverse | input | 1 | Inverse coding convention for both directions |
| cfg_tx_par | input | 2 | Transmit parity: 01 even, 10 odd, else none |
| cfg_rx_par | input | 2 | Receive parity: 01 even, 10 odd, else none |
| cfg_rx_nine | input | 1 | Receive eight data bits plus a ninth, without parity |
| tx_push | input | 1 | Push tx_data into the transmit queue |
| tx_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit queue full |
| tx_drop | output | 1 | One-cycle flag: the previous push was discarded |
| rx_pop | input | 1 | Remove the head entry of the receive queue |
| rx_data | output | 9 | Head entry data; bit 8 is the ninth bit |
| rx_perr | output | 1 | Head entry parity error flag |
| rx_empty | output | 1 | Receive queue empty |
| io_in | input | 1 | Level of the card I/O line |
| io_oe | output | 1 | Pull the card I/O line low |

## Verification
Transmit framing is tried with bytes that have an odd and an even number of ones, all-ones, a single set bit at either end, and at two ETU lengths. This separates the even/odd/none parity choices and exposes bit-order or bit-count errors. The same bytes in inverse convention tell a complement-only or reorder-only bug apart from a correct inverse encoding. On the receive side, every format is used, including a deliberately corrupted parity bit, ninth-bit values of 0 and 1, and back-to-back characters with one and two stop bits. A burst that overfills each queue shows which entries are kept and which are lost.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10
  } par_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_STOP
  } rx_st_t;
endpackage

// File: rtl/sc_fifo.sv
module sc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_wr, do_rd;

  assign full    = (cnt == FULL_CNT);
  assign empty   = (cnt == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/sc_tx.sv
module sc_tx
  import sc_pkg::*;
#(
  parameter int ETU_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ETU_W-1:0] etu,
  input  logic             inverse,
  input  logic [1:0]       par,
  input  logic             q_empty,
  input  logic [7:0]       q_data,
  output logic             q_pop,
  output logic             busy,
  output logic             line_low
);
  localparam int FR_W = 12;

  logic [FR_W-1:0]  sh;
  logic [3:0]       left;
  logic [ETU_W-1:0] cnt;
  logic [7:0]       ld;
  logic             par_en, pbit;
  logic [FR_W-1:0]  frame;

  always_comb begin
    for (int i = 0; i < 8; i++) ld[i] = inverse ? ~q_data[7-i] : q_data[i];
    par_en = (par_t'(par) == PAR_EVEN) || (par_t'(par) == PAR_ODD);
    pbit   = (par_t'(par) == PAR_ODD) ? ~^ld : ^ld;
    frame  = par_en ? {2'b11, pbit, ld, 1'b0} : {3'b111, ld, 1'b0};
  end

  assign q_pop    = !busy && !q_empty;
  assign line_low = ~sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      left <= '0;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (q_pop) begin
      sh   <= frame;
      left <= par_en ? 4'd12 : 4'd11;
      cnt  <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == etu - 1'b1) begin
        cnt  <= '0;
        sh   <= {1'b1, sh[FR_W-1:1]};
        left <= left - 1'b1;
        if (left == 4'd1) busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sc_rx.sv
module sc_rx
  import sc_pkg::*;
#(
  parameter int ETU_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ETU_W-1:0] etu,
  input  logic             inverse,
  input  logic [1:0]       par,
  input  logic             nine,
  input  logic             line_in,
  input  logic             hold,
  output logic             wr_en,
  output logic [9:0]       wr_data
);
  rx_st_t           st;
  logic [ETU_W-1:0] cnt;
  logic [3:0]       idx, nb;
  logic [8:0]       raw;
  logic             s1, ln;
  logic [7:0]       dec;
  logic             ninth, perr;

  always_comb begin
    for (int i = 0; i < 8; i++) dec[i] = inverse ? ~raw[7-i] : raw[i];
    ninth = nine && (inverse ? ~raw[8] : raw[8]);
    if (nine)                          perr = 1'b0;
    else if (par_t'(par) == PAR_EVEN)  perr = ^raw;
    else if (par_t'(par) == PAR_ODD)   perr = ~^raw;
    else                               perr = 1'b0;
    nb = (nine || par_t'(par) == PAR_EVEN || par_t'(par) == PAR_ODD) ? 4'd9 : 4'd8;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      ln <= 1'b1;
    end else begin
      s1 <= line_in;
      ln <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= RX_IDLE;
      cnt     <= '0;
      idx     <= '0;
      raw     <= '0;
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      case (st)
        RX_IDLE: begin
          cnt <= '0;
          if (!hold && !ln) st <= RX_START;
        end
        RX_START: begin
          if (cnt == (etu >> 1)) begin
            cnt <= '0;
            idx <= '0;
            st  <= ln ? RX_IDLE : RX_BITS;
          end else cnt <= cnt + 1'b1;
        end
        RX_BITS: begin
          if (cnt == etu - 1'b1) begin
            cnt      <= '0;
            raw[idx] <= ln;
            if (idx == nb - 1'b1) st <= RX_STOP;
            else idx <= idx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (cnt == etu - 1'b1) begin
            wr_en   <= 1'b1;
            wr_data <= {perr, ninth, dec};
            st      <= RX_IDLE;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/sc_char_if.sv
module sc_char_if #(
  parameter int ETU_W = 12,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ETU_W-1:0] cfg_etu,
  input  logic             cfg_inverse,
  input  logic [1:0]       cfg_tx_par,
  input  logic [1:0]       cfg_rx_par,
  input  logic             cfg_rx_nine,
  input  logic             tx_push,
  input  logic [7:0]       tx_data,
  output logic             tx_full,
  output logic             tx_drop,
  input  logic             rx_pop,
  output logic [8:0]       rx_data,
  output logic             rx_perr,
  output logic             rx_empty,
  input  logic             io_in,
  output logic             io_oe
);
  logic [7:0] txq_data;
  logic       txq_empty, tx_pop, tx_busy;
  logic       rx_wr, rx_full;
  logic [9:0] rx_wdata, rx_head;

  sc_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .wr_en(tx_push), .wr_data(tx_data),
    .rd_en(tx_pop), .rd_data(txq_data), .full(tx_full), .empty(txq_empty)
  );

  sc_tx #(.ETU_W(ETU_W)) u_tx (
    .clk(clk), .rst(rst), .etu(cfg_etu), .inverse(cfg_inverse), .par(cfg_tx_par),
    .q_empty(txq_empty), .q_data(txq_data), .q_pop(tx_pop),
    .busy(tx_busy), .line_low(io_oe)
  );

  sc_rx #(.ETU_W(ETU_W)) u_rx (
    .clk(clk), .rst(rst), .etu(cfg_etu), .inverse(cfg_inverse), .par(cfg_rx_par),
    .nine(cfg_rx_nine), .line_in(io_in), .hold(tx_busy),
    .wr_en(rx_wr), .wr_data(rx_wdata)
  );

  sc_fifo #(.W(10), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .wr_en(rx_wr), .wr_data(rx_wdata),
    .rd_en(rx_pop), .rd_data(rx_head), .full(rx_full), .empty(rx_empty)
  );

  assign rx_data = rx_head[8:0];
  assign rx_perr = rx_head[9];

  always_ff @(posedge clk) begin
    if (rst) tx_drop <= 1'b0;
    else     tx_drop <= tx_push && tx_full;
  end
endmodule

// File: rtl/sc_char_if_chk.sv
module sc_char_if_chk (
  input logic clk,
  input logic rst,
  input logic tx_push,
  input logic tx_full,
  input logic tx_drop,
  input logic tx_pop,
  input logic tx_busy,
  input logic io_oe,
  input logic rx_pop,
  input logic rx_empty,
  input logic rx_full,
  input logic rx_wr
);
  p_drop_cause_r5: assert property (@(posedge clk) disable iff (rst)
    tx_drop |-> $past(tx_push && tx_full));

  p_full_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_full && !tx_pop) |=> tx_full);

  p_idle_release_r4: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> !io_oe);

  p_empty_pop_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_empty && rx_pop && !rx_wr) |=> rx_empty);

  p_rx_full_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !rx_pop) |=> rx_full);
endmodule

bind sc_char_if sc_char_if_chk u_chk (
  .clk(clk), .rst(rst), .tx_push(tx_push), .tx_full(tx_full), .tx_drop(tx_drop),
  .tx_pop(tx_pop), .tx_busy(tx_busy), .io_oe(io_oe), .rx_pop(rx_pop),
  .rx_empty(rx_empty), .rx_full(rx_full), .rx_wr(rx_wr)
);

// File: tb/sim_sc_char_if.sv
module sim_sc_char_if;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] cfg_etu = 12'd6;
  logic        cfg_inverse = 1'b0;
  logic [1:0]  cfg_tx_par = 2'b01;
  logic [1:0]  cfg_rx_par = 2'b01;
  logic        cfg_rx_nine = 1'b0;
  logic        tx_push = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        rx_pop = 1'b0;
  logic        card_low = 1'b0;
  logic        tx_full, tx_drop, rx_perr, rx_empty, io_oe, line;
  logic [8:0]  rx_data;

  int errors = 0;
  int checks = 0;
  int drops  = 0;
  logic [15:0] txq[$];
  logic [9:0]  rxq[$];

  always #10 clk = ~clk;
  assign line = ~io_oe & ~card_low;

  sc_char_if u0 (
    .clk(clk), .rst(rst), .cfg_etu(cfg_etu), .cfg_inverse(cfg_inverse),
    .cfg_tx_par(cfg_tx_par), .cfg_rx_par(cfg_rx_par), .cfg_rx_nine(cfg_rx_nine),
    .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full), .tx_drop(tx_drop),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_perr(rx_perr), .rx_empty(rx_empty),
    .io_in(line), .io_oe(io_oe)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] line_bits(input logic [7:0] d, input logic inv);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = inv ? ~d[7-i] : d[i];
    return r;
  endfunction

  // expected transmit frame: {nbits, 12 line bits, start first}
  function automatic logic [15:0] tx_frame(input logic [7:0] d);
    logic [7:0] ld;
    ld = line_bits(d, cfg_inverse);
    if (cfg_tx_par == 2'b01) return {4'd12, 2'b11, ^ld, ld, 1'b0};
    if (cfg_tx_par == 2'b10) return {4'd12, 2'b11, ~^ld, ld, 1'b0};
    return {4'd11, 3'b111, ld, 1'b0};
  endfunction

  task automatic push_one(input logic [7:0] b);
    logic [15:0] f;
    f = tx_frame(b);
    @(negedge clk);
    tx_push = 1'b1;
    tx_data = b;
    @(negedge clk);
    tx_push = 1'b0;
    if (tx_drop) drops++;
    else txq.push_back(f);
  endtask

  // monitor: decode frames on the line at mid-bit
  initial begin
    forever begin
      logic [11:0] got;
      logic [15:0] e;
      int n;
      @(negedge clk);
      if (io_oe) begin
        got = '1;
        repeat (cfg_etu / 2) @(negedge clk);
        got[0] = line;
        n = (txq.size() > 0) ? int'(txq[0][15:12]) : 12;
        for (int k = 1; k < n; k++) begin
          repeat (cfg_etu) @(negedge clk);
          got[k] = line;
        end
        if (txq.size() == 0) check(1'b0, "R5 unexpected frame", {4'd0, got}, 16'h0);
        else begin
          e = txq.pop_front();
          check(got == e[11:0], cfg_inverse ? "R3 tx frame" : "R2 R4 tx frame", {4'd0, got}, e);
        end
      end
    end
  end

  task automatic wait_tx();
    int guard = 0;
    while (txq.size() != 0 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (cfg_etu * 3) @(negedge clk);
  endtask

  // card sends a character; inj flips the parity bit
  task automatic send_rx(input logic [8:0] d9, input bit inj, input int stops, input bit keep);
    logic [9:0] bits;
    logic [7:0] ld;
    int nb;
    logic pe;
    ld = line_bits(d9[7:0], cfg_inverse);
    bits = {2'b00, ld};
    nb = 8;
    pe = 1'b0;
    if (cfg_rx_nine) begin
      bits[8] = cfg_inverse ? ~d9[8] : d9[8];
      nb = 9;
    end else if (cfg_rx_par == 2'b01 || cfg_rx_par == 2'b10) begin
      bits[8] = ((cfg_rx_par == 2'b01) ? ^ld : ~^ld) ^ inj;
      pe = inj;
      nb = 9;
    end
    @(negedge clk);
    card_low = 1'b1;
    repeat (cfg_etu) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      card_low = ~bits[k];
      repeat (cfg_etu) @(negedge clk);
    end
    card_low = 1'b0;
    repeat (cfg_etu * stops) @(negedge clk);
    if (keep) rxq.push_back({pe, cfg_rx_nine ? d9[8] : 1'b0, d9[7:0]});
  endtask

  task automatic drain(input string req);
    logic [9:0] e;
    repeat (cfg_etu * 2) @(negedge clk);
    while (!rx_empty) begin
      e = (rxq.size() > 0) ? rxq.pop_front() : 10'h3ff;
      check({rx_perr, rx_data} == e, req, {6'd0, rx_perr, rx_data}, {6'd0, e});
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
    end
    check(rxq.size() == 0, {req, " count"}, 16'(rxq.size()), 16'd0);
    rxq.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(io_oe == 1'b0, "R1 io_oe", 16'(io_oe), 16'd0);
    check(tx_full == 1'b0, "R1 tx_full", 16'(tx_full), 16'd0);
    check(tx_drop == 1'b0, "R1 tx_drop", 16'(tx_drop), 16'd0);
    check(rx_empty == 1'b1, "R1 rx_empty", 16'(rx_empty), 16'd1);

    // R2 parity choices, direct convention
    cfg_tx_par = 2'b01; push_one(8'hA5); push_one(8'h3C); wait_tx();
    cfg_tx_par = 2'b10; push_one(8'h01); push_one(8'h80); wait_tx();
    cfg_tx_par = 2'b00; push_one(8'hFF); wait_tx();
    // R3 inverse transmit
    cfg_inverse = 1'b1;
    cfg_tx_par = 2'b01; push_one(8'h3F); wait_tx();
    cfg_tx_par = 2'b10; push_one(8'h80); push_one(8'h03); wait_tx();
    cfg_inverse = 1'b0;
    // R10 own transmission not received
    check(rx_empty == 1'b1, "R10 echo ignored", 16'(rx_empty), 16'd1);

    // R5 overflow: one in flight plus 16 stored, 3 dropped
    cfg_tx_par = 2'b01;
    for (int k = 0; k < 20; k++) push_one(8'(k * 7 + 1));
    check(drops == 3, "R5 drop count", 16'(drops), 16'd3);
    wait_tx();
    check(rx_empty == 1'b1, "R10 echo ignored after burst", 16'(rx_empty), 16'd1);

    // R6 R7 receive with parity
    cfg_rx_par = 2'b01;
    send_rx(9'h05A, 0, 2, 1); send_rx(9'h000, 0, 2, 1); send_rx(9'h0F1, 1, 2, 1);
    drain("R6 R7 rx even");
    cfg_rx_par = 2'b10;
    send_rx(9'h0C3, 0, 2, 1); send_rx(9'h07E, 1, 2, 1);
    drain("R6 R7 rx odd");
    // R11 one and two stop bits, no parity
    cfg_rx_par = 2'b00;
    send_rx(9'h011, 0, 1, 1); send_rx(9'h0EE, 0, 1, 1); send_rx(9'h081, 0, 1, 1);
    send_rx(9'h042, 0, 2, 1); send_rx(9'h024, 0, 2, 1);
    drain("R11 rx stop bits");
    // R8 ninth bit
    cfg_rx_nine = 1'b1;
    send_rx(9'h1AB, 0, 1, 1); send_rx(9'h055, 0, 1, 1);
    drain("R8 rx nine");
    // R3 inverse receive
    cfg_inverse = 1'b1;
    send_rx(9'h101, 0, 1, 1); send_rx(9'h0C0, 0, 1, 1);
    drain("R3 R8 rx inverse nine");
    cfg_rx_nine = 1'b0; cfg_rx_par = 2'b01;
    send_rx(9'h03F, 0, 2, 1); send_rx(9'h0D2, 1, 2, 1);
    drain("R3 R7 rx inverse even");
    cfg_inverse = 1'b0;

    // R9 overflow: 17th character lost
    for (int k = 0; k < 17; k++) send_rx(9'(k * 13), 0, 2, k < 16);
    drain("R9 rx overflow");
    rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0; @(negedge clk);
    check(rx_empty == 1'b1, "R9 pop on empty", 16'(rx_empty), 16'd1);
    send_rx(9'h099, 0, 2, 1);
    drain("R9 after empty pop");

    // R2 R6 longer ETU
    cfg_etu = 12'd9;
    push_one(8'h6B); wait_tx();
    send_rx(9'h0B6, 0, 2, 1);
    drain("R6 rx etu 9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule